// File: doc/BRIEF.md
# Timing Error Detecting Pipeline Stage

This block is a pipeline register that lets the supply voltage run below its worst-case value. Every data bit is captured twice: once by a main flop on the normal clock edge and once by a shadow flop on a second clock that rises a fixed margin later. If a signal arrives late, the main flop holds the stale value and the shadow flop holds the settled one. One cycle after the capture, the two words are compared. A difference raises a one-cycle stage error, and the stage forwards the shadow word in place of the main word.

A small recovery controller reacts to each stage error. It first gives a one-cycle flush pulse to the surrounding pipeline, which then replays the failing operation. It then holds a slow-mode request for a programmable number of cycles, so that the clock source can stretch its period during the replay. A saturating error counter lets an outside voltage controller measure the fault rate. That controller lowers the supply until the rate is still tolerable. It reads the counter and clears it at the end of each sampling window.

The paths that feed the stage must meet a minimum delay. Data for the next operation must not reach the shadow flop before the late edge has taken its sample. The late clock and the datapath between stages lie outside this block.

Top module: `tspec_stage`

## Requirements
- R1: Each bit of `d_in` is captured by a main flop on the rising edge of `clk` and by a shadow flop on the rising edge of `clk_late`. If the two captured words differ in any bit, `stage_err` is 1 for the one cycle that follows the next rising edge of `clk`.
- R2: `stage_err` stays 0 whenever the two captured words agree. This holds in the cycles right after reset, after a flush, and when the data changes between the two edges to the value it already had.
- R3: `q_out` shows the captured word one cycle after the capture. When the words disagree, `q_out` shows the shadow (late) word.
- R4: While `rst_n` is low and after it is released, `q_out`, `stage_err`, `flush`, `slow_req` and `err_count` are 0.
- R5: `flush` is 1 for exactly the cycle that follows each cycle in which `stage_err` is 1.
- R6: After a flush cycle, `slow_req` is 1 for exactly N cycles and then returns to 0. N is the value of `slow_len` at the clock edge where the error was seen. If N is 0, `slow_req` stays 0. `flush` and `slow_req` are never 1 together.
- R7: A new `stage_err` during the flush or slow cycles restarts the sequence with a fresh flush cycle and a fresh length taken from `slow_len`.
- R8: `err_count` increases by one on the edge after each cycle in which `stage_err` is 1. It holds at 2^CNT_W-1 and does not wrap.
- R9: `cnt_clear` high at an edge sets `err_count` to 0 at that edge. The clear takes precedence over an increment due at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Normal pipeline clock |
| clk_late | input | 1 | Delayed sampling clock for the shadow flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | WIDTH | Data arriving from the upstream logic |
| slow_len | input | SLOW_W | Number of slow-mode cycles after a flush |
| cnt_clear | input | 1 | Clears the error counter |
| q_out | output | WIDTH | Registered (and corrected) stage data |
| stage_err | output | 1 | Timing fault detected in the previous capture |
| flush | output | 1 | One-cycle pipeline flush request |
| slow_req | output | 1 | Request for a longer clock period |
| err_count | output | CNT_W | Saturating count of detected faults |

## Verification
A stale main word, or a compare that misses one bit, shows at the ports one cycle after the late capture: `q_out` carries the wrong value and `stage_err` has the wrong level. A controller that starts in the wrong state or keeps a wrong length shows within a few cycles of a fault. The flush pulse would be missing or doubled, or `slow_req` would be held one cycle too long or too short. A wrong count shows on the edge after the fault, and it is plainest at saturation and when a clear meets an increment.

// File: rtl/tspec_pkg.sv
package tspec_pkg;

  typedef enum logic [1:0] {
    RC_RUN   = 2'd0,
    RC_FLUSH = 2'd1,
    RC_SLOW  = 2'd2
  } rc_state_e;

endpackage

// File: rtl/tspec_capture.sv
module tspec_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clk_late,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out,
  output logic             stage_err
);

  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] shadow_q;
  logic [WIDTH-1:0] bit_diff;
  logic             any_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) main_q <= '0;
    else        main_q <= d_in;
  end

  always_ff @(posedge clk_late or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= d_in;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_cmp
    assign bit_diff[g] = main_q[g] ^ shadow_q[g];
  end

  assign any_diff = |bit_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_out     <= '0;
      stage_err <= 1'b0;
    end else begin
      q_out     <= any_diff ? shadow_q : main_q;
      stage_err <= any_diff;
    end
  end

  AST_AGREE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == shadow_q) |=> (!stage_err && q_out == $past(main_q))); // R2
  AST_DIFF_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q != shadow_q) |=> (stage_err && q_out == $past(shadow_q))); // R3

endmodule

// File: rtl/tspec_recovery.sv
module tspec_recovery
  import tspec_pkg::*;
#(
  parameter int SLOW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_in,
  input  logic [SLOW_W-1:0] slow_len,
  output logic              flush,
  output logic              slow_req
);

  rc_state_e         state;
  logic [SLOW_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RC_RUN;
      left  <= '0;
    end else if (err_in) begin
      state <= RC_FLUSH;
      left  <= slow_len;
    end else begin
      case (state)
        RC_FLUSH: state <= (left == '0) ? RC_RUN : RC_SLOW;
        RC_SLOW: begin
          left <= left - 1'b1;
          if (left == {{(SLOW_W-1){1'b0}}, 1'b1}) state <= RC_RUN;
        end
        default: state <= RC_RUN;
      endcase
    end
  end

  assign flush    = (state == RC_FLUSH);
  assign slow_req = (state == RC_SLOW);

  AST_FLUSH_FOLLOWS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> flush); // R5
  AST_SLOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !err_in && left != '0) |=> slow_req); // R6
  AST_SLOW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_req && !err_in && left == {{(SLOW_W-1){1'b0}}, 1'b1}) |=> !slow_req); // R6
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush, slow_req})); // R6

endmodule

// File: rtl/tspec_errcnt.sv
module tspec_errcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_in,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (err_in) count <= sat_inc(count);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clear) |=> (count == CNT_MAX)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0)); // R9

endmodule

// File: rtl/tspec_stage.sv
module tspec_stage #(
  parameter int WIDTH  = 8,
  parameter int SLOW_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              clk_late,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  d_in,
  input  logic [SLOW_W-1:0] slow_len,
  input  logic              cnt_clear,
  output logic [WIDTH-1:0]  q_out,
  output logic              stage_err,
  output logic              flush,
  output logic              slow_req,
  output logic [CNT_W-1:0]  err_count
);

  tspec_capture #(.WIDTH(WIDTH)) u_capture (
    .clk       (clk),
    .clk_late  (clk_late),
    .rst_n     (rst_n),
    .d_in      (d_in),
    .q_out     (q_out),
    .stage_err (stage_err)
  );

  tspec_recovery #(.SLOW_W(SLOW_W)) u_recovery (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_in   (stage_err),
    .slow_len (slow_len),
    .flush    (flush),
    .slow_req (slow_req)
  );

  tspec_errcnt #(.CNT_W(CNT_W)) u_errcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_in (stage_err),
    .clear  (cnt_clear),
    .count  (err_count)
  );

  AST_FLUSH_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    stage_err |=> flush); // R5

endmodule

// File: tb/tspec_stage_tb.sv
module tspec_stage_tb;

  localparam int WIDTH  = 8;
  localparam int SLOW_W = 4;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              clk_late = 1'b0;
  logic              rst_n = 1'b0;
  logic [WIDTH-1:0]  d_in = '0;
  logic [SLOW_W-1:0] slow_len = '0;
  logic              cnt_clear = 1'b0;
  logic [WIDTH-1:0]  q_out;
  logic              stage_err;
  logic              flush;
  logic              slow_req;
  logic [CNT_W-1:0]  err_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int e_q = 0, e_err = 0, e_flush = 0, e_slow = 0, e_cnt = 0;
  int m_st = 0, m_left = 0;
  int sm = 0, ss = 0;

  tspec_stage #(.WIDTH(WIDTH), .SLOW_W(SLOW_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .clk_late(clk_late), .rst_n(rst_n), .d_in(d_in),
    .slow_len(slow_len), .cnt_clear(cnt_clear), .q_out(q_out),
    .stage_err(stage_err), .flush(flush), .slow_req(slow_req),
    .err_count(err_count)
  );

  initial forever #10 clk = ~clk;
  initial begin
    #16;
    forever begin clk_late = 1'b1; #10; clk_late = 1'b0; #10; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 q_out", int'(q_out), e_q);
    chk("R1 stage_err", int'(stage_err), e_err);
    chk("R5 flush", int'(flush), e_flush);
    chk("R6 slow_req", int'(slow_req), e_slow);
    chk("R8 err_count", int'(err_count), e_cnt);
  endtask

  // model of one rising clk edge, from the requirements
  task automatic model_edge(input bit clr);
    int old_err;
    old_err = e_err;
    e_err = (sm != ss) ? 1 : 0;
    e_q   = e_err ? ss : sm;
    if (clr) e_cnt = 0;
    else if (old_err != 0 && e_cnt < CMAX) e_cnt++;
    if (old_err != 0) begin
      m_st = 1; m_left = int'(slow_len);
    end else if (m_st == 1) begin
      m_st = (m_left == 0) ? 0 : 2;
    end else if (m_st == 2) begin
      if (m_left == 1) m_st = 0;
      m_left--;
    end
    e_flush = (m_st == 1) ? 1 : 0;
    e_slow  = (m_st == 2) ? 1 : 0;
  endtask

  // one cycle: early value before clk edge, optional late change before clk_late edge
  task automatic cyc(input int early, input bit late, input int lv, input bit clr);
    d_in = early[WIDTH-1:0];
    cnt_clear = clr;
    @(posedge clk);
    model_edge(clr);
    sm = early;
    if (late) begin
      #3;
      d_in = lv[WIDTH-1:0];
      ss = lv;
    end else begin
      ss = early;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all(); // R4 outputs held at zero in reset
    rst_n = 1'b1;
    check_all(); // R4
    // R2 plain traffic after reset, no fault
    cyc('hA5, 0, 0, 0);
    cyc('h5A, 0, 0, 0);
    cyc('hFF, 0, 0, 0);
    cyc('h00, 0, 0, 0);
    // R1 R3 R5 R6 late arrival with slow length 3
    slow_len = 4'd3;
    cyc('h11, 1, 'h2A, 0);
    repeat (6) cyc('h3C, 0, 0, 0);
    // R6 slow length zero: flush only
    slow_len = 4'd0;
    cyc('h80, 1, 'h00, 0);
    repeat (4) cyc('h42, 0, 0, 0);
    // R7 second fault while in slow mode restarts sequence
    slow_len = 4'd4;
    cyc('h01, 1, 'h03, 0);
    cyc('h07, 0, 0, 0);
    cyc('h09, 0, 0, 0);
    slow_len = 4'd2;
    cyc('h0F, 1, 'hF0, 0);
    repeat (7) cyc('h66, 0, 0, 0);
    // R2 late change to the same value is not a fault
    cyc('h33, 1, 'h33, 0);
    repeat (2) cyc('h44, 0, 0, 0);
    // R9 clear meets a due increment
    cyc('h01, 1, 'h02, 0);
    cyc('h10, 0, 0, 0);
    cyc('h10, 0, 0, 1);
    repeat (4) cyc('h20, 0, 0, 0);
    // R8 saturation with back-to-back faults
    slow_len = 4'd1;
    for (int i = 0; i < 20; i++) cyc(i, 1, i ^ 'h55, 0);
    repeat (4) cyc('h77, 0, 0, 0);
    // R9 plain clear at saturation
    cyc('h77, 0, 0, 1);
    cyc('h77, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule